// File: doc/BRIEF.md
# I2C Register-Map Target Port

This block is an I2C target that lets a bus master reach a small bank of byte-wide registers owned by the surrounding logic. It watches SCL and SDA from the system clock, finds START and STOP conditions, and answers one 7-bit chip address. The upper six bits of that address are a parameter and the lowest bit follows a strap input. SDA is open-drain: the block only ever pulls the line low through `sda_pull_o`.

A write transaction carries a pointer byte first and data bytes after it. Each data byte is handed to the register owner as a one-cycle write strobe, and the pointer advances after every byte. A read transaction has no pointer byte of its own: it returns bytes starting at wherever the pointer was left. A master positions the pointer with a write that stops right after the pointer byte, then reads. A repeated START between the two phases works the same way.

The register owner supplies read data combinationally for the address on `rd_addr_o`. It sees writes only for implemented addresses.

Top module: `i2c_regmap_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {ADDR_HI, ad0_i}; bit 0 of that byte selects read (1) or write (0). After any other address byte it never pulls SDA low until the next START.
- R2: In a write transaction the byte after the address byte is loaded into the pointer and acknowledged.
- R3: Each later data byte of a write is acknowledged in the ninth clock. It produces one `wr_en_o` pulse carrying the current pointer and the byte, and then the pointer advances.
- R4: A STOP directly after the pointer byte's acknowledge causes no write and keeps the pointer, so a following read starts at that pointer.
- R5: In a read the block acknowledges the address and then drives the selected byte MSB first. It changes SDA only while SCL is low.
- R6: Each byte the master acknowledges in a read is followed by the next register. After the master leaves a byte unacknowledged, SDA stays released, and a STOP always releases SDA.
- R7: The pointer advances from NUM_REGS-1 to 0, for both reads and writes.
- R8: When the pointer is NUM_REGS or more, reads return 0x00 and writes are acknowledged but raise no `wr_en_o`; the next advance takes the pointer to 0.
- R9: A START at any bit position restarts address reception, so a transaction interrupted in mid-byte does not disturb the next one.
- R10: During and after reset, SDA is released and no write strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| ad0_i | input | 1 | Strap that sets address bit 0 |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_addr_o | output | 8 | Register index being read (current pointer) |
| rd_data_i | input | 8 | Contents of the register at rd_addr_o |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 8 | Register index for the write |
| wr_data_o | output | 8 | Byte to write |

## Verification
The bench builds the block with NUM_REGS set to 6, which is small enough that a two-byte burst crosses the 5-to-0 wrap in both directions. Pointer bytes such as 0x40 then land in the unimplemented range. In that range the bench's register model returns 0xEE, so any leak of owner data past the zero-fill shows up. The default address prefix and the two-stage synchronisers are kept, and the strap is switched mid-run to prove that the low address bit follows the pin.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_MAP,
        PH_WRITE,
        PH_READ,
        PH_SKIP
    } phase_e;

    // Decoded bus events in the system clock domain
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl_lvl;
        logic sda_lvl;
    } line_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [5:0] hi, input logic ad0);
        return b[7:1] == {hi, ad0};
    endfunction

    // Pointer advance: past the last implemented register (or from outside the map) back to 0
    function automatic logic [7:0] ptr_next(input logic [7:0] p, input int unsigned n);
        return (p >= 8'(n - 1)) ? 8'd0 : p + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync import i2c_tgt_pkg::*; #(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_s, sda_s, scl_d, sda_d;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    always_comb begin
        ev_o.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev_o.scl_rise = ~scl_d & scl_s;
        ev_o.scl_fall = scl_d & ~scl_s;
        ev_o.scl_lvl  = scl_s;
        ev_o.sda_lvl  = sda_s;
    end

endmodule

// File: rtl/i2c_map_ptr.sv
module i2c_map_ptr import i2c_tgt_pkg::*; #(
    parameter int NUM_REGS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       inc,
    output logic [7:0] ptr,
    output logic       ptr_ok
);
    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    assign ptr_ok = {1'b0, ptr} < LIMIT;

    always_ff @(posedge clk) begin
        if (rst)       ptr <= 8'd0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr_next(ptr, NUM_REGS);
    end

    // R7: advancing from the last register returns to 0
    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && ptr == 8'(NUM_REGS - 1)) |=> ptr == 8'd0);

    // R2: a pointer byte is taken as is
    a_r2_map_load: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr == $past(load_val));

endmodule

// File: rtl/i2c_frame_engine.sv
module i2c_frame_engine import i2c_tgt_pkg::*; #(
    parameter logic [5:0] ADDR_HI = 6'b100111
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic       ad0,
    input  logic [7:0] ptr,
    input  logic       ptr_ok,
    input  logic [7:0] rd_byte,
    output logic       map_load,
    output logic [7:0] map_val,
    output logic       map_inc,
    output wr_req_t    wr,
    output logic       sda_pull
);
    phase_e     phase, nxt;
    logic [3:0] cnt;
    logic [7:0] shreg, tx;
    logic       edge_ok, fire;
    logic [7:0] fetch;

    always_comb begin
        edge_ok  = !ev.start && !ev.stop && phase != PH_IDLE && phase != PH_SKIP;
        fire     = edge_ok && ev.scl_fall && cnt == 4'd8;
        map_load = fire && phase == PH_MAP;
        map_val  = shreg;
        map_inc  = fire && (phase == PH_WRITE || phase == PH_READ);
        fetch    = ptr_ok ? rd_byte : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            nxt      <= PH_IDLE;
            cnt      <= 4'd0;
            shreg    <= 8'd0;
            tx       <= 8'd0;
            sda_pull <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                phase    <= PH_ADDR;
                cnt      <= 4'd0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                cnt      <= 4'd0;
                sda_pull <= 1'b0;
            end else if (edge_ok && ev.scl_rise) begin
                cnt <= cnt + 4'd1;
                if (cnt < 4'd8) begin
                    shreg <= {shreg[6:0], ev.sda_lvl};
                end else if (phase == PH_READ) begin
                    // ninth clock of a read byte: master's acknowledge
                    if (ev.sda_lvl) phase <= PH_SKIP;
                    else            tx    <= fetch;
                end
            end else if (edge_ok && ev.scl_fall) begin
                if (cnt == 4'd8) begin
                    case (phase)
                        PH_ADDR: begin
                            if (addr_hit(shreg, ADDR_HI, ad0)) begin
                                sda_pull <= 1'b1;
                                nxt      <= shreg[0] ? PH_READ : PH_MAP;
                                tx       <= fetch;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_MAP: begin
                            sda_pull <= 1'b1;
                            nxt      <= PH_WRITE;
                        end
                        PH_WRITE: begin
                            sda_pull <= 1'b1;
                            nxt      <= PH_WRITE;
                            wr.en    <= ptr_ok;
                            wr.addr  <= ptr;
                            wr.data  <= shreg;
                        end
                        default: begin
                            sda_pull <= 1'b0;
                            nxt      <= PH_READ;
                        end
                    endcase
                end else if (cnt == 4'd9) begin
                    cnt      <= 4'd0;
                    phase    <= nxt;
                    sda_pull <= (nxt == PH_READ) ? ~tx[7] : 1'b0;
                end else if (phase == PH_READ && cnt != 4'd0) begin
                    sda_pull <= ~tx[6];
                    tx       <= {tx[6:0], 1'b0};
                end
            end
        end
    end

    // R1: no pull outside an addressed transaction
    a_r1_quiet_when_unaddressed: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_pull);

    // R5: SDA moves only after SCL was seen low (START/STOP aside)
    a_r5_sda_moves_with_scl_low: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pull) && !$past(ev.start) && !$past(ev.stop)) |-> !$past(ev.scl_lvl));

    // R6: a STOP releases SDA
    a_r6_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_pull);

    // R3: write strobes come only from the data phase of a write
    a_r3_strobe_from_write: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> $past(phase) == PH_WRITE);

endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target import i2c_tgt_pkg::*; #(
    parameter int         NUM_REGS    = 16,
    parameter logic [5:0] ADDR_HI     = 6'b100111,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ad0_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [7:0] rd_addr_o,
    input  logic [7:0] rd_data_i,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o
);
    line_ev_t   ev;
    wr_req_t    wr;
    logic       map_load, map_inc, ptr_ok;
    logic [7:0] map_val, ptr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
    );

    i2c_map_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
        .clk(clk), .rst(rst), .load(map_load), .load_val(map_val),
        .inc(map_inc), .ptr(ptr), .ptr_ok(ptr_ok)
    );

    i2c_frame_engine #(.ADDR_HI(ADDR_HI)) u_eng (
        .clk(clk), .rst(rst), .ev(ev), .ad0(ad0_i), .ptr(ptr), .ptr_ok(ptr_ok),
        .rd_byte(rd_data_i), .map_load(map_load), .map_val(map_val),
        .map_inc(map_inc), .wr(wr), .sda_pull(sda_pull_o)
    );

    assign rd_addr_o = ptr;
    assign wr_en_o   = wr.en;
    assign wr_addr_o = wr.addr;
    assign wr_data_o = wr.data;

    // R8: strobes never name an unimplemented register
    a_r8_no_write_outside: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> {1'b0, wr_addr_o} < 9'(NUM_REGS));

endmodule

// File: tb/sim_i2c_regmap_target.sv
`timescale 1ns/1ps
module sim_i2c_regmap_target;
    localparam int NREGS = 6;
    localparam int QTR   = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ad0 = 1'b1;
    logic scl_b = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line, sda_pull;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic wr_en;

    int checks = 0;
    int errors = 0;
    logic pull_ok = 1'b1;

    logic [7:0] file_q [NREGS];   // register owner seen by the block
    logic [7:0] exp_regs [NREGS]; // reference model
    int         exp_map = 0;
    logic [15:0] wq [$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign rd_data  = (int'(rd_addr) < NREGS) ? file_q[rd_addr[2:0]] : 8'hEE;

    i2c_regmap_target #(.NUM_REGS(NREGS)) u0 (
        .clk(clk), .rst(rst), .ad0_i(ad0), .scl_i(scl_b), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nxt_map(input int m);
        return (m >= NREGS - 1) ? 0 : m + 1;
    endfunction

    // Per-clock monitor: register owner, write log and line rules
    logic scl_prev = 1'b1;
    logic pull_prev = 1'b0;
    always @(posedge clk) begin
        if (!rst && wr_en && int'(wr_addr) < NREGS) file_q[wr_addr[2:0]] <= wr_data;
    end
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) wq.push_back({wr_addr, wr_data});
            checks++;
            if (scl_b && scl_prev && sda_pull != pull_prev) begin
                errors++;
                $display("FAIL R5 SDA moved while SCL high actual=%0b expected=%0b", sda_pull, pull_prev);
            end
            if (!pull_ok && sda_pull) begin
                errors++;
                $display("FAIL R1 pull after unmatched address actual=1 expected=0");
            end
        end
        scl_prev  <= scl_b;
        pull_prev <= sda_pull;
    end

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_b = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_b = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_b = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic bus_bit(input logic b, output logic s);
        sda_m = b;    wait_q();
        scl_b = 1'b1; wait_q();
        s = sda_line; wait_q();
        scl_b = 1'b0; wait_q();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            v[i] = s;
        end
        bus_bit(!give_ack, s);
    endtask

    task automatic open_tx(input logic [7:0] abyte, input int exp_ack, input string req);
        logic a;
        bus_start();
        put_byte(abyte, a);
        chk(req, a, exp_ack);
    endtask

    task automatic send_map(input logic [7:0] m);
        logic a;
        put_byte(m, a);
        chk("R2 pointer byte ack", a, 1);
        exp_map = m;
    endtask

    task automatic send_data(input logic [7:0] d);
        logic a;
        put_byte(d, a);
        chk("R3 data byte ack", a, 1);
        if (exp_map < NREGS) begin
            chk("R3 one strobe per byte", wq.size(), 1);
            if (wq.size() > 0) chk("R3 strobe address/data", wq.pop_front(), {exp_map[7:0], d});
            exp_regs[exp_map] = d;
        end else begin
            chk("R8 no strobe outside map", wq.size(), 0);
            wq.delete();
        end
        exp_map = nxt_map(exp_map);
    endtask

    task automatic read_chk(input logic give_ack, input string req);
        logic [7:0] v;
        get_byte(give_ack, v);
        chk(req, v, (exp_map < NREGS) ? exp_regs[exp_map] : 0);
        exp_map = nxt_map(exp_map);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic s;
        for (int i = 0; i < NREGS; i++) begin
            file_q[i]   = 8'h00;
            exp_regs[i] = 8'h00;
        end
        repeat (10) @(negedge clk);
        chk("R10 SDA released in reset", sda_pull, 0);
        chk("R10 no strobe in reset", wr_en, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 SDA released after reset", sda_pull, 0);

        // R1: wrong low address bit, then a byte of ones: nothing acknowledged
        pull_ok = 1'b0;
        open_tx(8'h9C, 0, "R1 mismatched address nack");
        put_byte(8'hFF, s);
        chk("R1 no ack after mismatch", s, 0);
        bus_stop();
        pull_ok = 1'b1;

        // R2/R3: burst write from pointer 2
        open_tx(8'h9E, 1, "R1 matched write address ack");
        send_map(8'd2);
        send_data(8'hA5);
        send_data(8'h3C);
        send_data(8'h81);
        bus_stop();

        // R4: aborted write sets pointer, then read
        open_tx(8'h9E, 1, "R1 write address ack");
        send_map(8'd3);
        bus_stop();
        chk("R4 aborted write strobes nothing", wq.size(), 0);
        open_tx(8'h9F, 1, "R5 read address ack");
        read_chk(1'b0, "R4 read at kept pointer");
        bus_stop();
        repeat (8) @(negedge clk);
        chk("R6 SDA released after nack and stop", sda_pull, 0);

        // R7: write across the wrap
        open_tx(8'h9E, 1, "R1 write address ack");
        send_map(8'd5);
        send_data(8'h5A);
        send_data(8'h0F);
        bus_stop();

        // R6/R7: repeated START into a three-byte read crossing the wrap
        open_tx(8'h9E, 1, "R1 write address ack");
        send_map(8'd4);
        open_tx(8'h9F, 1, "R5 read after repeated start ack");
        read_chk(1'b1, "R5 first read byte");
        read_chk(1'b1, "R6 next read byte");
        read_chk(1'b0, "R7 read after wrap");
        repeat (4) @(negedge clk);
        chk("R6 SDA released after master nack", sda_pull, 0);
        bus_stop();

        // R8: pointer outside the map
        open_tx(8'h9E, 1, "R1 write address ack");
        send_map(8'h40);
        bus_stop();
        open_tx(8'h9F, 1, "R5 read address ack");
        read_chk(1'b0, "R8 read outside map is zero");
        bus_stop();
        open_tx(8'h9E, 1, "R1 write address ack");
        send_map(8'h40);
        send_data(8'h77);
        open_tx(8'h9F, 1, "R5 read address ack");
        read_chk(1'b0, "R8 pointer went to 0 after outside write");
        bus_stop();

        // R9: START in the middle of an address byte
        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
        open_tx(8'h9E, 1, "R9 address after mid-byte start");
        send_map(8'd1);
        send_data(8'h66);
        bus_stop();

        // R1: strap low moves the address
        ad0 = 1'b0;
        repeat (4) @(negedge clk);
        open_tx(8'h9C, 1, "R1 address follows strap");
        send_map(8'd1);
        bus_stop();
        open_tx(8'h9D, 1, "R1 read address follows strap");
        read_chk(1'b0, "R9 register written after restart");
        bus_stop();
        pull_ok = 1'b0;
        open_tx(8'h9E, 0, "R1 old address now ignored");
        bus_stop();
        pull_ok = 1'b1;

        repeat (20) @(negedge clk);
        chk("R3 no stray strobes", wq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule